// File: doc/BRIEF.md
# Asynchronous Timer Clock Source Selector and Prescaler

This block decides what drives an 8-bit asynchronous timer and how fast that timer counts. Three control bits choose the count source: the system I/O clock, a 32 kHz crystal oscillator, an external clock applied to the oscillator input pad, or a separate alternate clock pad. The same decode turns the crystal oscillator on or off and reports which of three shared pads remain usable as general-purpose I/O. Every source arrives as a one-cycle tick-enable in the single clock domain of the block, so no clock is ever switched or generated.

The selected tick drives a 10-bit divider. A 3-bit field chooses one of eight outputs: stop, undivided, or division by 8, 32, 64, 128, 256 or 1024. The output is a one-cycle tick-enable for the timer counter. A one-cycle software pulse clears the divider, which makes the phase of the next divided tick predictable. The block also holds the timer's interrupt-mask register. This register gates the overflow, compare-A and compare-B flags with a global interrupt enable to form three interrupt requests.

Top module: `tclk_select_top`

## Requirements
- R1: After reset the mask register reads 0x00 and the divider count is zero. With division by N selected, the N-th selected source tick after reset is the first one that produces an output tick.
- R2: With `cs_async`=0 and `cs_ext`=0, the source is `tick_io` whatever `cs_alt` is. `osc_en` is 0 and `pad_free` is 3'b111.
- R3: With `cs_async`=0 and `cs_ext`=1 (undefined), no source is selected. The divider receives no ticks, `osc_en` is 0 and `pad_free` is 3'b000.
- R4: With `cs_async`=1, `cs_ext`=0 and `cs_alt`=0, the source is `tick_xtal`, `osc_en` is 1 and `pad_free` is 3'b001.
- R5: With `cs_async`=1, `cs_ext`=1 and `cs_alt`=0, the source is `tick_extin`, `osc_en` is 0 and `pad_free` is 3'b011.
- R6: With `cs_async`=1 and `cs_alt`=1, the source is `tick_altpad` and `osc_en` equals NOT `cs_ext`. `pad_free` is 3'b110 when `cs_ext`=1 and 3'b000 when `cs_ext`=0. In `pad_free`, bit 0 is the alternate clock pad, bit 1 is the oscillator output pad and bit 2 is the oscillator input pad.
- R7: `presc_sel` sets the division: 0 = stop (no output ticks), 1 = /1, 2 = /8, 3 = /32, 4 = /64, 5 = /128, 6 = /256, 7 = /1024. For /N, `cnt_tick` is high in the same cycle as every selected source tick that brings the count since zero to a multiple of N, and only then.
- R8: Ticks on source inputs that are not selected neither advance the divider nor produce `cnt_tick`.
- R9: A cycle with `presc_clr`=1 sets the divider count to zero. It overrides a source tick in the same cycle, and `cnt_tick` stays low in that cycle.
- R10: A cycle with `msk_we`=1 loads `msk_wdata[2:0]` into the mask: bit 2 = compare-B, bit 1 = compare-A, bit 0 = overflow. `msk_rdata` returns the mask in bits 2:0 and zero in bits 7:3, whatever was written there.
- R11: Each request `irq_ovf`, `irq_cmpa` and `irq_cmpb` is high exactly when its mask bit, `gie` and its flag input are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_async | input | 1 | Asynchronous-source select |
| cs_ext | input | 1 | External-clock select |
| cs_alt | input | 1 | Alternate-pad select |
| tick_io | input | 1 | System I/O clock tick-enable |
| tick_xtal | input | 1 | Crystal oscillator tick-enable |
| tick_extin | input | 1 | External clock on oscillator input pad, tick-enable |
| tick_altpad | input | 1 | Alternate clock pad tick-enable |
| presc_sel | input | 3 | Division select |
| presc_clr | input | 1 | One-cycle divider clear pulse |
| msk_we | input | 1 | Mask register write strobe |
| msk_wdata | input | 8 | Mask register write data |
| msk_rdata | output | 8 | Mask register read data |
| gie | input | 1 | Global interrupt enable |
| flag_ovf | input | 1 | Overflow flag |
| flag_cmpa | input | 1 | Compare-A flag |
| flag_cmpb | input | 1 | Compare-B flag |
| cnt_tick | output | 1 | Divided tick-enable for the timer counter |
| osc_en | output | 1 | Crystal oscillator enable |
| pad_free | output | 3 | Pads released for general-purpose I/O |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_cmpa | output | 1 | Compare-A interrupt request |
| irq_cmpb | output | 1 | Compare-B interrupt request |

## Verification
A divider clear and a selected source tick can land in the same cycle. The clear must win: the tick is not counted and produces no output. The bench forces this collision on purpose in a directed case, right before a /8 boundary. It then checks that `cnt_tick` is low in that cycle and that the next output comes exactly eight selected ticks later. The random phase also lets clears, source changes and division changes fall on tick cycles, and a cycle-by-cycle reference counter in the bench judges every one of them.

// File: rtl/tclk_pkg.sv
package tclk_pkg;

  typedef enum logic [2:0] {
    SRC_NONE   = 3'd0,
    SRC_IOCLK  = 3'd1,
    SRC_XTAL   = 3'd2,
    SRC_EXTIN  = 3'd3,
    SRC_ALTPAD = 3'd4
  } src_e;

  typedef struct packed {
    src_e       src;
    logic       osc_en;
    logic [2:0] pad_free;   // [0] alt clock pad, [1] osc output pad, [2] osc input pad
  } route_t;

  // Source, oscillator and pad-release decode
  function automatic route_t decode_route(logic async_sel, logic ext_sel, logic alt_sel);
    route_t r;
    r = '{src: SRC_NONE, osc_en: 1'b0, pad_free: 3'b000};
    if (!async_sel) begin
      if (!ext_sel) begin
        r.src      = SRC_IOCLK;
        r.pad_free = 3'b111;
      end
    end else if (alt_sel) begin
      r.src      = SRC_ALTPAD;
      r.osc_en   = ~ext_sel;
      r.pad_free = ext_sel ? 3'b110 : 3'b000;
    end else if (ext_sel) begin
      r.src      = SRC_EXTIN;
      r.pad_free = 3'b011;
    end else begin
      r.src      = SRC_XTAL;
      r.osc_en   = 1'b1;
      r.pad_free = 3'b001;
    end
    return r;
  endfunction

  // log2 of the division ratio for each select code (code 0 is handled as stop)
  function automatic logic [3:0] div_log2(logic [2:0] sel);
    logic [3:0] k;
    case (sel)
      3'd2:    k = 4'd3;
      3'd3:    k = 4'd5;
      3'd4:    k = 4'd6;
      3'd5:    k = 4'd7;
      3'd6:    k = 4'd8;
      3'd7:    k = 4'd10;
      default: k = 4'd0;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/tclk_src_route.sv
module tclk_src_route
  import tclk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_async,
  input  logic       cs_ext,
  input  logic       cs_alt,
  input  logic       tick_io,
  input  logic       tick_xtal,
  input  logic       tick_extin,
  input  logic       tick_altpad,
  output logic       src_tick,
  output logic       osc_en,
  output logic [2:0] pad_free
);

  route_t route;
  logic   undef_combo;

  assign route       = decode_route(cs_async, cs_ext, cs_alt);
  assign osc_en      = route.osc_en;
  assign pad_free    = route.pad_free;
  assign undef_combo = ~cs_async & cs_ext;

  always_comb begin
    unique case (route.src)
      SRC_IOCLK:  src_tick = tick_io;
      SRC_XTAL:   src_tick = tick_xtal;
      SRC_EXTIN:  src_tick = tick_extin;
      SRC_ALTPAD: src_tick = tick_altpad;
      default:    src_tick = 1'b0;
    endcase
  end

  AST_UNDEF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    undef_combo |-> (!src_tick && !osc_en && pad_free == 3'b000)); // R3
  AST_OSC_HOLDS_PADS: assert property (@(posedge clk) disable iff (!rst_n)
    osc_en |-> (pad_free[2:1] == 2'b00)); // R4
  AST_IO_FREES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_async && !cs_ext) |-> (pad_free == 3'b111 && !osc_en)); // R2

endmodule

// File: rtl/tclk_prescaler.sv
module tclk_prescaler
  import tclk_pkg::*;
#(
  parameter int MAX_LOG2 = 10,
  parameter int SEL_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_tick,
  input  logic [SEL_W-1:0] sel,
  input  logic             clr,
  output logic             tick_out
);

  localparam int CNT_W = MAX_LOG2;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] low_mask;
  logic [3:0]       div_k;
  logic             stopped;
  logic             boundary;
  logic             advance;

  assign div_k   = div_log2(sel);
  assign stopped = (sel == '0);
  assign advance = src_tick & ~clr;

  always_comb begin
    for (int i = 0; i < CNT_W; i++) begin
      low_mask[i] = (i < int'(div_k));
    end
  end

  assign boundary = ((cnt_q & low_mask) == low_mask);
  assign tick_out = advance & ~stopped & boundary;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (src_tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_tick && !clr) |=> $stable(cnt_q)); // R8
  AST_STOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |-> !tick_out); // R7
  AST_OUT_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    tick_out |-> src_tick); // R8

endmodule

// File: rtl/tclk_irq_mask.sv
module tclk_irq_mask #(
  parameter int REG_W = 8,
  parameter int IRQ_N = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  input  logic             gie,
  input  logic [IRQ_N-1:0] flags,
  output logic [IRQ_N-1:0] irqs
);

  logic [IRQ_N-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (we) begin
      mask_q <= wdata[IRQ_N-1:0];
    end
  end

  assign rdata = {{(REG_W-IRQ_N){1'b0}}, mask_q};

  for (genvar g = 0; g < IRQ_N; g++) begin : g_gate
    assign irqs[g] = gie & mask_q[g] & flags[g];
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[REG_W-1:IRQ_N] == '0); // R10
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (rdata[IRQ_N-1:0] == $past(wdata[IRQ_N-1:0]))); // R10
  AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    (irqs != '0) |-> gie); // R11
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ((irqs & ~flags) == '0)); // R11

endmodule

// File: rtl/tclk_select_top.sv
module tclk_select_top #(
  parameter int MAX_LOG2 = 10,
  parameter int SEL_W    = 3,
  parameter int REG_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_async,
  input  logic             cs_ext,
  input  logic             cs_alt,
  input  logic             tick_io,
  input  logic             tick_xtal,
  input  logic             tick_extin,
  input  logic             tick_altpad,
  input  logic [SEL_W-1:0] presc_sel,
  input  logic             presc_clr,
  input  logic             msk_we,
  input  logic [REG_W-1:0] msk_wdata,
  output logic [REG_W-1:0] msk_rdata,
  input  logic             gie,
  input  logic             flag_ovf,
  input  logic             flag_cmpa,
  input  logic             flag_cmpb,
  output logic             cnt_tick,
  output logic             osc_en,
  output logic [2:0]       pad_free,
  output logic             irq_ovf,
  output logic             irq_cmpa,
  output logic             irq_cmpb
);

  localparam int IRQ_N = 3;

  logic             src_tick;
  logic [IRQ_N-1:0] flags;
  logic [IRQ_N-1:0] irqs;

  tclk_src_route u_route (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_async   (cs_async),
    .cs_ext     (cs_ext),
    .cs_alt     (cs_alt),
    .tick_io    (tick_io),
    .tick_xtal  (tick_xtal),
    .tick_extin (tick_extin),
    .tick_altpad(tick_altpad),
    .src_tick   (src_tick),
    .osc_en     (osc_en),
    .pad_free   (pad_free)
  );

  tclk_prescaler #(
    .MAX_LOG2(MAX_LOG2),
    .SEL_W   (SEL_W)
  ) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_tick(src_tick),
    .sel     (presc_sel),
    .clr     (presc_clr),
    .tick_out(cnt_tick)
  );

  assign flags = {flag_cmpb, flag_cmpa, flag_ovf};

  tclk_irq_mask #(
    .REG_W(REG_W),
    .IRQ_N(IRQ_N)
  ) u_mask (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (msk_we),
    .wdata(msk_wdata),
    .rdata(msk_rdata),
    .gie  (gie),
    .flags(flags),
    .irqs (irqs)
  );

  assign irq_ovf  = irqs[0];
  assign irq_cmpa = irqs[1];
  assign irq_cmpb = irqs[2];

  AST_CLR_BEATS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    presc_clr |-> !cnt_tick); // R9

endmodule

// File: tb/test_tclk_select_top.sv
module test_tclk_select_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_async = 0, cs_ext = 0, cs_alt = 0;
  logic       tick_io = 0, tick_xtal = 0, tick_extin = 0, tick_altpad = 0;
  logic [2:0] presc_sel = 3'd1;
  logic       presc_clr = 0;
  logic       msk_we = 0;
  logic [7:0] msk_wdata = 8'h00;
  logic [7:0] msk_rdata;
  logic       gie = 0, flag_ovf = 0, flag_cmpa = 0, flag_cmpb = 0;
  logic       cnt_tick, osc_en, irq_ovf, irq_cmpa, irq_cmpb;
  logic [2:0] pad_free;

  int unsigned n_chk = 0;
  int unsigned n_fail = 0;
  int unsigned mcnt = 0;       // reference divider count
  logic [2:0]  mmask = 3'b000; // reference mask

  always #5 clk = ~clk;

  tclk_select_top i_tclk_select_top (
    .clk(clk), .rst_n(rst_n),
    .cs_async(cs_async), .cs_ext(cs_ext), .cs_alt(cs_alt),
    .tick_io(tick_io), .tick_xtal(tick_xtal), .tick_extin(tick_extin), .tick_altpad(tick_altpad),
    .presc_sel(presc_sel), .presc_clr(presc_clr),
    .msk_we(msk_we), .msk_wdata(msk_wdata), .msk_rdata(msk_rdata),
    .gie(gie), .flag_ovf(flag_ovf), .flag_cmpa(flag_cmpa), .flag_cmpb(flag_cmpb),
    .cnt_tick(cnt_tick), .osc_en(osc_en), .pad_free(pad_free),
    .irq_ovf(irq_ovf), .irq_cmpa(irq_cmpa), .irq_cmpb(irq_cmpb)
  );

  // ---- reference functions written from the requirements ----
  function automatic int unsigned ref_div(logic [2:0] s);
    int unsigned d;
    d = 0;
    if (s == 3'd1) d = 1;
    if (s == 3'd2) d = 8;
    if (s == 3'd3) d = 32;
    if (s == 3'd4) d = 64;
    if (s == 3'd5) d = 128;
    if (s == 3'd6) d = 256;
    if (s == 3'd7) d = 1024;
    return d;
  endfunction

  function automatic string mode_tag(logic a, logic e, logic m);
    if (!a) return e ? "R3" : "R2";
    if (m)  return "R6";
    return e ? "R5" : "R4";
  endfunction

  function automatic logic ref_osc(logic a, logic e, logic m);
    return (a && !e && !m) || (a && m && !e);
  endfunction

  function automatic logic [2:0] ref_pads(logic a, logic e, logic m);
    if (!a) return e ? 3'b000 : 3'b111;
    if (m)  return e ? 3'b110 : 3'b000;
    return e ? 3'b011 : 3'b001;
  endfunction

  function automatic logic ref_src(logic a, logic e, logic m,
                                   logic ti, logic tx, logic te, logic ta);
    if (!a) return e ? 1'b0 : ti;
    if (m)  return ta;
    return e ? te : tx;
  endfunction

  task automatic check(string req, int unsigned act, int unsigned exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Compare all outputs of the present cycle, then advance the reference
  // and move to the next falling edge. tick_req names the divider check.
  task automatic cycle(string tick_req);
    logic st, exp_tick;
    int unsigned d;
    #1;
    st = ref_src(cs_async, cs_ext, cs_alt, tick_io, tick_xtal, tick_extin, tick_altpad);
    d  = ref_div(presc_sel);
    exp_tick = !presc_clr && st && (d != 0) && ((mcnt % d) == d - 1);
    check(mode_tag(cs_async, cs_ext, cs_alt), osc_en, ref_osc(cs_async, cs_ext, cs_alt));
    check(mode_tag(cs_async, cs_ext, cs_alt), pad_free, ref_pads(cs_async, cs_ext, cs_alt));
    check(tick_req, cnt_tick, exp_tick);
    check("R10", msk_rdata, {5'b00000, mmask});
    check("R11", {irq_cmpb, irq_cmpa, irq_ovf},
          {3{gie}} & mmask & {flag_cmpb, flag_cmpa, flag_ovf});
    if (presc_clr) mcnt = 0;
    else if (st) mcnt = (mcnt + 1) % 1024;
    if (msk_we) mmask = msk_wdata[2:0];
    @(negedge clk);
  endtask

  task automatic quiet();
    tick_io = 0; tick_xtal = 0; tick_extin = 0; tick_altpad = 0;
    presc_clr = 0; msk_we = 0;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int unsigned seed;
    int unsigned seen;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, then the 8th io tick after reset gives the first /8 output
    #1;
    check("R1", msk_rdata, 0);
    @(negedge clk);
    presc_sel = 3'd2;
    seen = 0;
    for (int i = 0; i < 8; i++) begin
      tick_io = 1;
      #1;
      if (cnt_tick) seen = i + 1;
      cycle("R1");
    end
    check("R1", seen, 8);
    quiet();

    // R8: crystal mode ignores every other source
    cs_async = 1; cs_ext = 0; cs_alt = 0; presc_sel = 3'd1;
    for (int i = 0; i < 20; i++) begin
      tick_io = 1; tick_extin = (i % 2 == 0); tick_altpad = (i % 3 == 0);
      cycle("R8");
    end
    quiet();
    presc_sel = 3'd2;
    for (int i = 0; i < 8; i++) begin
      tick_xtal = 1; tick_io = 1;
      cycle("R8");
    end
    quiet();

    // R9: clear collides with a tick just before the /8 boundary
    cs_async = 0; presc_clr = 1; cycle("R9"); quiet();
    for (int i = 0; i < 7; i++) begin tick_io = 1; cycle("R9"); end
    tick_io = 1; presc_clr = 1;
    #1; check("R9", cnt_tick, 0);
    cycle("R9");
    quiet();
    seen = 0;
    for (int i = 0; i < 8; i++) begin
      tick_io = 1;
      #1;
      if (cnt_tick) seen = i + 1;
      cycle("R9");
    end
    check("R9", seen, 8);
    quiet();

    // R7: stop and /1024 directed
    presc_sel = 3'd0;
    for (int i = 0; i < 10; i++) begin tick_io = 1; cycle("R7"); end
    presc_clr = 1; presc_sel = 3'd7; cycle("R7"); quiet();
    seen = 0;
    for (int i = 0; i < 1024; i++) begin
      tick_io = 1;
      #1;
      if (cnt_tick) seen++;
      cycle("R7");
    end
    check("R7", seen, 1);
    quiet();

    // R10: reserved bits ignored
    msk_we = 1; msk_wdata = 8'hFA; cycle("R10"); quiet();
    #1; check("R10", msk_rdata, 8'h02);
    @(negedge clk);

    // Every decode combination, then random traffic (R2..R7, R10, R11)
    for (int c = 0; c < 8; c++) begin
      {cs_async, cs_ext, cs_alt} = c[2:0];
      cycle("R7");
    end
    for (int i = 0; i < 6000; i++) begin
      if ($urandom % 40 == 0) {cs_async, cs_ext, cs_alt} = 3'($urandom);
      if ($urandom % 60 == 0) presc_sel = 3'($urandom % 4);
      tick_io     = ($urandom % 2 == 0);
      tick_xtal   = ($urandom % 3 == 0);
      tick_extin  = ($urandom % 2 == 0);
      tick_altpad = ($urandom % 4 != 0);
      presc_clr   = ($urandom % 150 == 0);
      msk_we      = ($urandom % 20 == 0);
      msk_wdata   = 8'($urandom);
      gie         = ($urandom % 4 != 0);
      {flag_cmpb, flag_cmpa, flag_ovf} = 3'($urandom);
      cycle(presc_clr ? "R9" : "R7");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule